// File: doc/BRIEF.md
# Row-ordered pixel delta encoder

This block takes the zero-suppressed hits of one chip region, which arrive grouped by column, and sends them out sorted by row. Each output hit is a triple of row delta, column delta and ADC value. The deltas are taken against the hit sent just before it. Sorting by row before taking differences keeps the position values small and regular. This suits the three entropy coders that sit downstream, one for each field of the triple.

During an event, every accepted hit is written into the FIFO of its own column. Each FIFO entry holds the row and the ADC value. The event is closed with an event-end handshake, and the block then drains. In each cycle a merge selects, among the heads of all non-empty column FIFOs, the one with the smallest row, and the lowest column when rows are equal. That hit is presented as a triple on a single valid/ready channel. When all FIFOs are empty, a done pulse closes the event. Differences then restart from row 0, column 0.

Top module: `pix_row_delta_enc`

## Requirements
- R1: After reset, out_valid_o and done_o are low, evt_end_ready_o is high, and hit_ready_o is high for any column index below NUM_COLS.
- R2: A hit is written when hit_valid_i and hit_ready_o are both high. hit_ready_o is low while the addressed column already holds FIFO_DEPTH hits, and it is low throughout the drain phase. An offered hit that is not accepted leaves the output stream unchanged.
- R3: No triple is offered while hits are being collected. Once the event end has been accepted, out_valid_o is high in the next cycle if the event holds any hit.
- R4: Within one column, hits arrive in ascending row order. Output hits appear in ascending row order, and hits with equal rows appear in ascending column order.
- R5: row_delta_o is the hit's row minus the previous output hit's row, as an (ROW_W+1)-bit two's-complement value. col_delta_o is the column difference, as a (COL_W+1)-bit two's-complement value.
- R6: adc_o carries the hit's ADC value unchanged.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o and all three output fields hold their values at the next clock edge.
- R8: After the last triple of an event has been transferred, done_o is high for exactly one cycle, with out_valid_o low. In that same cycle evt_end_ready_o is high again, and the number of triples sent equals the number of hits accepted. An empty event produces a done pulse and no triples.
- R9: The first triple of every event is taken relative to row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | Input hit offered |
| hit_ready_o | output | 1 | Input hit can be written |
| hit_col_i | input | COL_W | Column of the hit within the region |
| hit_row_i | input | ROW_W | Row of the hit |
| hit_adc_i | input | ADC_W | ADC value of the hit |
| evt_end_valid_i | input | 1 | Event end offered |
| evt_end_ready_o | output | 1 | Event end can be accepted (collect phase) |
| out_valid_o | output | 1 | Triple offered |
| out_ready_i | input | 1 | Downstream takes the triple |
| row_delta_o | output | ROW_W+1 | Signed row difference |
| col_delta_o | output | COL_W+1 | Signed column difference |
| adc_o | output | ADC_W | ADC value |
| done_o | output | 1 | One-cycle pulse once the event has drained |

## Verification
A wrong merge choice, or a wrong reference position, shows in the very next transferred triple: the delta no longer adds up to the expected position. An error in the reference position then persists until the event's done pulse. A FIFO pointer fault either drops a hit, which shows as a short triple count at done_o, or replays a stale entry with a wrong ADC value. A phase error shows as a triple offered during collection, or as a done pulse that is missing or repeated, within one cycle of the event end.

// File: rtl/pix_delta_pkg.sv
package pix_delta_pkg;
  typedef enum logic {PH_COLLECT = 1'b0, PH_DRAIN = 1'b1} phase_e;
endpackage

// File: rtl/pix_col_fifo.sv
module pix_col_fifo #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pix_head_select.sv
module pix_head_select #(
  parameter int unsigned NUM_COLS = 41,
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned ADC_W    = 5,
  parameter int unsigned CIDX_W   = 6
) (
  input  logic [NUM_COLS-1:0]            avail_i,
  input  logic [NUM_COLS-1:0][ROW_W-1:0] head_row_i,
  input  logic [NUM_COLS-1:0][ADC_W-1:0] head_adc_i,
  output logic                           any_o,
  output logic [CIDX_W-1:0]              sel_o,
  output logic [ROW_W-1:0]               row_o,
  output logic [ADC_W-1:0]               adc_o
);
  // strict less-than over ascending columns keeps the lowest column on a tie
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    row_o = '0;
    adc_o = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (avail_i[c] && (!any_o || head_row_i[c] < row_o)) begin
        any_o = 1'b1;
        sel_o = CIDX_W'(c);
        row_o = head_row_i[c];
        adc_o = head_adc_i[c];
      end
    end
  end
endmodule

// File: rtl/pix_delta_stage.sv
module pix_delta_stage #(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic             clear_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [ROW_W:0]   row_delta_o,
  output logic [COL_W:0]   col_delta_o
);
  logic [ROW_W-1:0] prev_row_q;
  logic [COL_W-1:0] prev_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_row_q <= '0;
      prev_col_q <= '0;
    end else if (clear_i) begin
      prev_row_q <= '0;
      prev_col_q <= '0;
    end else if (advance_i) begin
      prev_row_q <= row_i;
      prev_col_q <= col_i;
    end
  end

  assign row_delta_o = {1'b0, row_i} - {1'b0, prev_row_q};
  assign col_delta_o = {1'b0, col_i} - {1'b0, prev_col_q};

  // R4
  row_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |-> row_i >= prev_row_q);
endmodule

// File: rtl/pix_row_delta_enc.sv
module pix_row_delta_enc
  import pix_delta_pkg::*;
#(
  parameter int unsigned NUM_COLS   = 41,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ROW_W      = 10,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned ADC_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_valid_i,
  output logic             hit_ready_o,
  input  logic [COL_W-1:0] hit_col_i,
  input  logic [ROW_W-1:0] hit_row_i,
  input  logic [ADC_W-1:0] hit_adc_i,
  input  logic             evt_end_valid_i,
  output logic             evt_end_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [ROW_W:0]   row_delta_o,
  output logic [COL_W:0]   col_delta_o,
  output logic [ADC_W-1:0] adc_o,
  output logic             done_o
);
  localparam int unsigned CIDX_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int unsigned ENTRY_W = ROW_W + ADC_W;

  phase_e phase_q;
  logic   done_q;
  logic   collecting, tgt_full, hit_fire, out_fire, any_head, drained;

  logic [NUM_COLS-1:0]            push, pop, empty, full;
  logic [NUM_COLS-1:0][ROW_W-1:0] head_row;
  logic [NUM_COLS-1:0][ADC_W-1:0] head_adc;
  logic [CIDX_W-1:0]              sel_col;
  logic [ROW_W-1:0]               sel_row;

  assign collecting = (phase_q == PH_COLLECT);

  always_comb begin
    tgt_full = 1'b1;  // out-of-region column is never accepted
    for (int c = 0; c < NUM_COLS; c++) begin
      if (hit_col_i == COL_W'(c)) tgt_full = full[c];
    end
  end

  assign hit_ready_o     = collecting && !tgt_full;
  assign hit_fire        = hit_valid_i && hit_ready_o;
  assign evt_end_ready_o = collecting;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [ENTRY_W-1:0] head;
    assign push[c] = hit_fire && (hit_col_i == COL_W'(c));
    assign pop[c]  = out_fire && (sel_col == CIDX_W'(c));

    pix_col_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .data_i  ({hit_row_i, hit_adc_i}),
      .pop_i   (pop[c]),
      .head_o  (head),
      .empty_o (empty[c]),
      .full_o  (full[c])
    );
    assign head_row[c] = head[ENTRY_W-1:ADC_W];
    assign head_adc[c] = head[ADC_W-1:0];
  end

  pix_head_select #(
    .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .ADC_W(ADC_W), .CIDX_W(CIDX_W)
  ) u_select (
    .avail_i    (~empty),
    .head_row_i (head_row),
    .head_adc_i (head_adc),
    .any_o      (any_head),
    .sel_o      (sel_col),
    .row_o      (sel_row),
    .adc_o      (adc_o)
  );

  assign out_valid_o = !collecting && any_head;
  assign out_fire    = out_valid_o && out_ready_i;
  assign drained     = !collecting && !any_head;

  pix_delta_stage #(.ROW_W(ROW_W), .COL_W(COL_W)) u_delta (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .advance_i   (out_fire),
    .clear_i     (drained),
    .row_i       (sel_row),
    .col_i       (COL_W'(sel_col)),
    .row_delta_o (row_delta_o),
    .col_delta_o (col_delta_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_COLLECT;
      done_q  <= 1'b0;
    end else begin
      done_q <= drained;
      if (collecting && evt_end_valid_i) phase_q <= PH_DRAIN;
      else if (drained)                  phase_q <= PH_COLLECT;
    end
  end

  assign done_o = done_q;

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(row_delta_o)
      && $stable(col_delta_o) && $stable(adc_o)));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!out_valid_o && evt_end_ready_o));
  // R3
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_fire |-> !out_valid_o);
endmodule

// File: tb/pix_row_delta_enc_bench.sv
`timescale 1ns/1ps
module pix_row_delta_enc_bench;
  localparam int NC = 6;
  localparam int D  = 4;
  localparam int RW = 10;
  localparam int CW = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_valid = 1'b0;
  logic [CW-1:0] hit_col = '0;
  logic [RW-1:0] hit_row = '0;
  logic [AW-1:0] hit_adc = '0;
  logic evt_end_valid = 1'b0;
  logic out_ready = 1'b0;
  logic hit_ready, evt_end_ready, out_valid, done;
  logic [RW:0] row_delta;
  logic [CW:0] col_delta;
  logic [AW-1:0] adc;

  always #2 clk = ~clk;

  pix_row_delta_enc #(
    .NUM_COLS(NC), .FIFO_DEPTH(D), .ROW_W(RW), .COL_W(CW), .ADC_W(AW)
  ) u_pix_row_delta_enc (
    .clk_i(clk), .rst_ni(rst_n),
    .hit_valid_i(hit_valid), .hit_ready_o(hit_ready),
    .hit_col_i(hit_col), .hit_row_i(hit_row), .hit_adc_i(hit_adc),
    .evt_end_valid_i(evt_end_valid), .evt_end_ready_o(evt_end_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .row_delta_o(row_delta), .col_delta_o(col_delta), .adc_o(adc),
    .done_o(done)
  );

  int errors = 0;
  int checks = 0;
  int cnt [NC];
  int hrow [NC][D];
  int hadc [NC][D];
  int er [NC*D];
  int ec [NC*D];
  int ea [NC*D];
  int n_exp;
  int perm [NC];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void clear_event();
    for (int c = 0; c < NC; c++) cnt[c] = 0;
  endfunction

  // expected output order: ascending (row, col)
  function automatic void build_expected();
    int t;
    n_exp = 0;
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < cnt[c]; k++) begin
        er[n_exp] = hrow[c][k]; ec[n_exp] = c; ea[n_exp] = hadc[c][k];
        n_exp++;
      end
    for (int i = 1; i < n_exp; i++)
      for (int j = i; j > 0; j--)
        if (er[j]*1024 + ec[j] < er[j-1]*1024 + ec[j-1]) begin
          t = er[j]; er[j] = er[j-1]; er[j-1] = t;
          t = ec[j]; ec[j] = ec[j-1]; ec[j-1] = t;
          t = ea[j]; ea[j] = ea[j-1]; ea[j-1] = t;
        end
  endfunction

  function automatic void random_event();
    int r;
    clear_event();
    for (int c = 0; c < NC; c++) begin
      r = int'($urandom % 60);
      for (int k = 0; k < int'($urandom % (D + 1)); k++) begin
        if (r > 647) break;
        hrow[c][k] = r; hadc[c][k] = int'($urandom % 32);
        cnt[c] = k + 1;
        r += 1 + int'($urandom % 120);
      end
    end
  endfunction

  task automatic run_event(input int probe_col);
    int idx, prow, pcol, cyc, act_row, act_col, h_rd, h_cd, h_adc;
    bit held;
    build_expected();
    for (int i = 0; i < NC; i++) perm[i] = i;
    for (int i = NC - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < NC; i++)
      for (int k = 0; k < cnt[perm[i]]; k++) begin
        @(negedge clk);
        hit_valid = 1'b1; hit_col = CW'(perm[i]);
        hit_row = RW'(hrow[perm[i]][k]); hit_adc = AW'(hadc[perm[i]][k]);
        #0.1;
        check(hit_ready === 1'b1, "R2 hit accepted", int'(hit_ready), 1);
        check(out_valid === 1'b0, "R3 silent while collecting", int'(out_valid), 0);
        @(posedge clk);
      end
    @(negedge clk);
    hit_valid = 1'b0;
    if (probe_col >= 0) begin
      hit_valid = 1'b1; hit_col = CW'(probe_col); hit_row = '0; hit_adc = 5'd31;
      #0.1;
      check(hit_ready === 1'b0, "R2 full column refused", int'(hit_ready), 0);
      hit_valid = 1'b0;
    end
    evt_end_valid = 1'b1;
    check(evt_end_ready === 1'b1, "R8 event end ready", int'(evt_end_ready), 1);
    @(posedge clk);
    @(negedge clk);
    evt_end_valid = 1'b0;
    #0.1;
    check(hit_ready === 1'b0, "R2 no hits while draining", int'(hit_ready), 0);
    check(out_valid === (n_exp > 0), "R3 output after event end", int'(out_valid), int'(n_exp > 0));
    idx = 0; prow = 0; pcol = 0; held = 0; cyc = 0;
    while (done !== 1'b1) begin
      if (held) begin
        check(out_valid === 1'b1 && row_delta == h_rd && col_delta == h_cd && adc == h_adc,
              "R7 held while stalled", int'(row_delta), h_rd);
      end
      out_ready = ($urandom % 3) != 0;
      held = 0;
      if (out_valid === 1'b1 && out_ready) begin
        if (idx < n_exp) begin
          check(row_delta == RW'(1)*0 + ((er[idx] - prow) & 'h7FF),
                idx == 0 ? "R9 first row delta" : "R5 row delta",
                int'(row_delta), (er[idx] - prow) & 'h7FF);
          check(col_delta == ((ec[idx] - pcol) & 'h1FF),
                idx == 0 ? "R9 first col delta" : "R5 col delta",
                int'(col_delta), (ec[idx] - pcol) & 'h1FF);
          check(adc == er[0]*0 + ea[idx], "R6 adc", int'(adc), ea[idx]);
          act_row = prow + int'($signed(row_delta));
          act_col = pcol + int'($signed(col_delta));
          check(act_row == er[idx] && act_col == ec[idx], "R4 order",
                act_row * 1024 + act_col, er[idx] * 1024 + ec[idx]);
          prow = er[idx]; pcol = ec[idx];
        end
        idx++;
      end else if (out_valid === 1'b1) begin
        held = 1; h_rd = int'(row_delta); h_cd = int'(col_delta); h_adc = int'(adc);
      end
      @(posedge clk);
      @(negedge clk);
      #0.1;
      cyc++;
      if (cyc > 2000) begin
        check(1'b0, "R8 drain timeout", cyc, 2000);
        break;
      end
    end
    out_ready = 1'b0;
    check(idx == n_exp, "R8 triple count", idx, n_exp);
    check(out_valid === 1'b0, "R8 idle at done", int'(out_valid), 0);
    check(evt_end_ready === 1'b1, "R8 ready at done", int'(evt_end_ready), 1);
    @(negedge clk);
    #0.1;
    check(done === 1'b0, "R8 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.1;
    // R1
    check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(evt_end_ready === 1'b1, "R1 evt_end_ready", int'(evt_end_ready), 1);
    check(hit_ready === 1'b1, "R1 hit_ready", int'(hit_ready), 1);

    // empty event
    clear_event();
    run_event(-1);

    // equal rows in every column: column order, R4
    clear_event();
    for (int c = 0; c < NC; c++) begin
      cnt[c] = 1; hrow[c][0] = 7; hadc[c][0] = 3 + c;
    end
    run_event(-1);

    // extreme positions and negative column delta, R5
    clear_event();
    cnt[0] = 2; hrow[0][0] = 0; hadc[0][0] = 1; hrow[0][1] = 647; hadc[0][1] = 31;
    cnt[NC-1] = 1; hrow[NC-1][0] = 0; hadc[NC-1][0] = 17;
    run_event(-1);

    // full column, extra hit refused, R2
    clear_event();
    for (int k = 0; k < D; k++) begin
      hrow[2][k] = 10 * k + 5; hadc[2][k] = k + 8;
    end
    cnt[2] = D;
    cnt[4] = 1; hrow[4][0] = 15; hadc[4][0] = 2;
    run_event(2);

    for (int e = 0; e < 40; e++) begin
      random_event();
      run_event(-1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule